// File: doc/BRIEF.md
# Prescaled Watchdog Down-Counter

This block is a down-counter with a programmable clock divider in front of it. It runs from the peripheral bus clock. Firmware uses it in one of two modes. As a watchdog, it raises a system reset request when software stops reloading it in time. As a plain periodic timer, it reloads itself at terminal count and sets a sticky flag, and it never requests a reset.

After any reset the counter is stopped and in timer mode. Watchdog behaviour exists only after firmware turns it on. Once watchdog mode is running, the control register is frozen until the next reset. This stops errant code from switching the watchdog off.

All inputs are single-cycle write strobes with their data, plus a kick strobe and a flag-clear strobe. The outputs are plain levels and pulses. No stream interface is involved, so there is no valid/ready handshake and no back-pressure.

Top module: `pwd_timer`

## Requirements
- R1: After reset the counter is stopped, the mode is timer, the counter and the reload value are all ones, the divider value is 0, and the flag and the reset request are low. While the counter is stopped and no load happens, the count output holds its value.
- R2: With divider value P, a running counter decrements once every P+1 clocks.
- R3: A control write that turns the counter on while it is stopped loads the count from the reload value and restarts the divider phase. The loaded value is visible one clock after the write.
- R4: A kick loads the count from the reload value and restarts the divider phase. The loaded value is visible one clock later. A reload-value write on its own leaves the count unchanged.
- R5: A divider tick that arrives while the count is 0 is a terminal tick. It reloads the count, so one full period lasts (reload+1)*(P+1) clocks.
- R6: In watchdog mode (mode input 1), each terminal tick drives the reset request high for one clock. The flag is not set.
- R7: In timer mode (mode input 0), a terminal tick sets the sticky flag and never drives the reset request. The flag stays set until a flag-clear strobe. If a clear arrives on the same clock as a terminal tick, the flag is set.
- R8: Once the counter is running in watchdog mode, control writes have no effect until the next reset. Both the on/off bit and the mode bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_presc | input | 1 | Write strobe for the divider value |
| presc_in | input | 8 | Divider value P |
| wr_reload | input | 1 | Write strobe for the reload value |
| reload_in | input | 16 | Reload value |
| wr_ctrl | input | 1 | Write strobe for the control bits |
| ctrl_en | input | 1 | Control bit: 1 runs the counter |
| ctrl_wdog | input | 1 | Control bit: 1 selects watchdog mode, 0 selects timer mode |
| kick | input | 1 | Reload strobe from firmware |
| flag_clr | input | 1 | Clears the terminal-count flag |
| count_o | output | 16 | Current count |
| tc_flag_o | output | 1 | Sticky terminal-count flag (timer mode) |
| rst_req_o | output | 1 | One-clock reset request (watchdog mode) |

## Verification
A wrong divider phase shows up as count_o stepping one or more clocks early or late after an enable or a kick. It is visible within P+1 clocks. A control register that is not truly locked shows up when a disable or mode write lets the count freeze or clears the flag path. The missing reset request then appears at the next expected expiry time. A wrong terminal-count rule moves the reset pulse or the flag by whole periods, and the exact clock of the pulse on rst_req_o and of the rise of tc_flag_o is checked.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_WDOG  = 1'b1
  } pwd_mode_e;
endpackage

// File: rtl/pwd_ctrl.sv
module pwd_ctrl
  import pwd_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_presc,
  input  logic [PW-1:0] presc_in,
  input  logic          wr_reload,
  input  logic [CW-1:0] reload_in,
  input  logic          wr_ctrl,
  input  logic          en_in,
  input  logic          mode_in,
  output logic [PW-1:0] presc_q,
  output logic [CW-1:0] reload_q,
  output logic          enable_q,
  output pwd_mode_e     mode_q,
  output logic          start
);
  logic locked;
  logic ctrl_ok;

  // Watchdog running: control bits frozen
  assign locked  = enable_q && (mode_q == MODE_WDOG);
  assign ctrl_ok = wr_ctrl && !locked;
  assign start   = ctrl_ok && en_in && !enable_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q  <= '0;
      reload_q <= '1;
      enable_q <= 1'b0;
      mode_q   <= MODE_TIMER;
    end else begin
      if (wr_presc)  presc_q  <= presc_in;
      if (wr_reload) reload_q <= reload_in;
      if (ctrl_ok) begin
        enable_q <= en_in;
        mode_q   <= pwd_mode_e'(mode_in);
      end
    end
  end

  AST_WDOG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q && mode_q == MODE_WDOG) |=> (enable_q && mode_q == MODE_WDOG)); // R8
endmodule

// File: rtl/pwd_prescaler.sv
module pwd_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          restart,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  logic [PW-1:0] phase;
  logic          wrap;

  assign wrap = (phase >= presc);
  assign tick = enable && !restart && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart) begin
      phase <= '0;
    end else if (enable) begin
      if (wrap) phase <= '0;
      else      phase <= phase + 1'b1;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != '0) |=> (!tick || presc == '0)); // R2
endmodule

// File: rtl/pwd_core.sv
module pwd_core
  import pwd_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  pwd_mode_e     mode,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] reload,
  input  logic          flag_clr,
  output logic [CW-1:0] count,
  output logic          tc_flag,
  output logic          rst_req
);
  logic term;

  assign term = tick && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '1;
      tc_flag <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (load || term) count <= reload;
      else if (tick)    count <= count - 1'b1;
      rst_req <= term && (mode == MODE_WDOG);
      if (term && mode == MODE_TIMER) tc_flag <= 1'b1;
      else if (flag_clr)              tc_flag <= 1'b0;
    end
  end

  AST_LOAD_TAKES_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(reload))); // R4
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load) |=> $stable(count)); // R1
  AST_RST_ONLY_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (mode == MODE_WDOG)); // R6
  AST_FLAG_ONLY_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> ($past(mode) == MODE_TIMER)); // R7
endmodule

// File: rtl/pwd_timer.sv
module pwd_timer
  import pwd_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_presc,
  input  logic [PW-1:0] presc_in,
  input  logic          wr_reload,
  input  logic [CW-1:0] reload_in,
  input  logic          wr_ctrl,
  input  logic          ctrl_en,
  input  logic          ctrl_wdog,
  input  logic          kick,
  input  logic          flag_clr,
  output logic [CW-1:0] count_o,
  output logic          tc_flag_o,
  output logic          rst_req_o
);
  logic [PW-1:0] presc_q;
  logic [CW-1:0] reload_q;
  logic          enable_q;
  pwd_mode_e     mode_q;
  logic          start;
  logic          load;
  logic          tick;

  assign load = kick || start;

  pwd_ctrl #(.CW(CW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_presc(wr_presc), .presc_in(presc_in),
    .wr_reload(wr_reload), .reload_in(reload_in),
    .wr_ctrl(wr_ctrl), .en_in(ctrl_en), .mode_in(ctrl_wdog),
    .presc_q(presc_q), .reload_q(reload_q),
    .enable_q(enable_q), .mode_q(mode_q), .start(start)
  );

  pwd_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst_n(rst_n), .enable(enable_q),
    .restart(load), .presc(presc_q), .tick(tick)
  );

  pwd_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable_q), .mode(mode_q),
    .tick(tick), .load(load), .reload(reload_q), .flag_clr(flag_clr),
    .count(count_o), .tc_flag(tc_flag_o), .rst_req(rst_req_o)
  );
endmodule

// File: tb/pwd_timer_test.sv
module pwd_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_presc = 1'b0, wr_reload = 1'b0, wr_ctrl = 1'b0;
  logic [7:0]  presc_in = '0;
  logic [15:0] reload_in = '0;
  logic        ctrl_en = 1'b0, ctrl_wdog = 1'b0, kick = 1'b0, flag_clr = 1'b0;
  logic [15:0] count_o;
  logic        tc_flag_o, rst_req_o;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int base;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwd_timer uut (
    .clk(clk), .rst_n(rst_n),
    .wr_presc(wr_presc), .presc_in(presc_in),
    .wr_reload(wr_reload), .reload_in(reload_in),
    .wr_ctrl(wr_ctrl), .ctrl_en(ctrl_en), .ctrl_wdog(ctrl_wdog),
    .kick(kick), .flag_clr(flag_clr),
    .count_o(count_o), .tc_flag_o(tc_flag_o), .rst_req_o(rst_req_o)
  );

  always @(negedge clk) if (rst_n && rst_req_o) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wait_n(2); rst_n = 1'b1;
  endtask

  task automatic w_presc(input logic [7:0] v);
    presc_in = v; wr_presc = 1'b1; wait_n(1); wr_presc = 1'b0;
  endtask

  task automatic w_reload(input logic [15:0] v);
    reload_in = v; wr_reload = 1'b1; wait_n(1); wr_reload = 1'b0;
  endtask

  task automatic w_ctrl(input logic en, input logic wd);
    ctrl_en = en; ctrl_wdog = wd; wr_ctrl = 1'b1; wait_n(1); wr_ctrl = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1; wait_n(1); kick = 1'b0;
  endtask

  task automatic do_clr();
    flag_clr = 1'b1; wait_n(1); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count_o, 32'hFFFF);
    chk("R1 flag", tc_flag_o, 0);
    chk("R1 rst_req", rst_req_o, 0);
    wait_n(8);
    chk("R1 hold while stopped", count_o, 32'hFFFF);
  endtask

  task automatic t_defaults();
    w_ctrl(1'b1, 1'b0);
    chk("R3 load on enable", count_o, 32'hFFFF);
    wait_n(3);
    chk("R2 divider 0 default", count_o, 32'hFFFC);
  endtask

  task automatic t_prescale_kick();
    do_reset();
    w_presc(8'd3); w_reload(16'd100); w_ctrl(1'b1, 1'b0);
    chk("R3 load", count_o, 100);
    wait_n(3);
    chk("R2 no step before P+1", count_o, 100);
    wait_n(1);
    chk("R2 step at P+1", count_o, 99);
    wait_n(8);
    chk("R2 steady rate", count_o, 97);
    wait_n(1);
    w_reload(16'd50);
    chk("R4 reload write keeps count", count_o, 97);
    do_kick();
    chk("R4 kick loads", count_o, 50);
    wait_n(3);
    chk("R4 phase restarted", count_o, 50);
    wait_n(1);
    chk("R4 first step after kick", count_o, 49);
  endtask

  task automatic t_timer();
    do_reset();
    base = pulses;
    w_presc(8'd2); w_reload(16'd3); w_ctrl(1'b1, 1'b0);
    wait_n(11);
    chk("R5 count at zero", count_o, 0);
    chk("R7 flag not yet", tc_flag_o, 0);
    flag_clr = 1'b1; wait_n(1); flag_clr = 1'b0;
    chk("R7 set wins over clear", tc_flag_o, 1);
    chk("R5 auto reload", count_o, 3);
    do_clr();
    chk("R7 clear", tc_flag_o, 0);
    wait_n(10);
    chk("R7 flag low mid period", tc_flag_o, 0);
    wait_n(1);
    chk("R7 second period flag", tc_flag_o, 1);
    chk("R7 no reset request in timer", pulses - base, 0);
  endtask

  task automatic t_wdog();
    do_reset();
    base = pulses;
    w_presc(8'd1); w_reload(16'd4); w_ctrl(1'b1, 1'b1);
    wait_n(9);
    chk("R6 no request early", rst_req_o, 0);
    chk("R5 count zero", count_o, 0);
    wait_n(1);
    chk("R6 request at expiry", rst_req_o, 1);
    chk("R5 reload at expiry", count_o, 4);
    chk("R6 flag untouched", tc_flag_o, 0);
    wait_n(1);
    chk("R6 one clock only", rst_req_o, 0);
    chk("R6 pulse count", pulses - base, 1);
  endtask

  task automatic t_kick_keeps();
    base = pulses;
    do_kick();
    for (int i = 0; i < 5; i++) begin
      wait_n(6);
      do_kick();
    end
    chk("R4 kicks prevent expiry", pulses - base, 0);
    chk("R4 count after kick", count_o, 4);
  endtask

  task automatic t_lock();
    do_kick();
    w_ctrl(1'b0, 1'b0);
    wait_n(8);
    chk("R8 still counting after disable write", count_o, 0);
    wait_n(1);
    chk("R8 still watchdog after write", rst_req_o, 1);
    do_reset();
    wait_n(5);
    chk("R8 unlocked and stopped after reset", count_o, 32'hFFFF);
  endtask

  initial begin
    fork
      begin
        wait_n(1);
        t_reset();
        t_defaults();
        t_prescale_kick();
        t_timer();
        t_wdog();
        t_kick_keeps();
        t_lock();
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule